// File: doc/BRIEF.md
# Oscillator Trim Search Controller

This controller finds the 5-bit trim code that brings a slow on-chip oscillator closest to its target. A one-cycle `start` begins a binary search over codes 0 to 31. For each candidate code the controller drives the code onto `trim_code`. It then raises `meas_req` to an external frequency meter and waits for `meas_ack`. The meter returns the number of reference clock periods that fit in one oscillator period, or a timeout flag. The result narrows the search interval.

A count inside the tolerance band ends the search at once. If no candidate lands in the band before the interval collapses, the two remaining endpoints are measured once more, left first and then right. The endpoint closer to the band's lower edge is chosen. The chosen code is presented on `final_code` with a one-cycle `done` pulse.

The counted value rises as the trim code rises. A large count therefore means the code is too high, and a small count means the code is too low.

Top module: `trim_search_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `trim_code`, `meas_req`, `done` and `final_code` are all 0 until a start is accepted.
- R2: A search begins with left bound 0 and right bound 31. Each step tries middle = floor((left + right) / 2). When middle equals left, the search phase ends without measuring that middle.
- R3: A measured count between 792 and 796 inclusive makes the controller output the middle code just measured, with no further measurement.
- R4: A count above 796 sets the right bound to middle. Any other count outside the band sets the left bound to middle.
- R5: A response with `meas_timeout` = 1 is treated as a count of 0 whatever `meas_count` carries, so it moves the left bound up.
- R6: When the search phase ends without a hit, the left bound is measured and then the right bound. The left code is chosen only if its absolute distance from 792 is strictly smaller than the right code's distance. Otherwise the right code is chosen.
- R7: `trim_code` already holds the new candidate in the cycle before `meas_req` rises. It stays unchanged until the acknowledge is taken.
- R8: `meas_req` stays high until a cycle with `meas_ack` = 1 and is low in the following cycle. Every search step or endpoint measurement issues exactly one request.
- R9: `done` is high for exactly one cycle. `final_code` changes only in that cycle and then holds its value.
- R10: `start` has no effect while a search is in progress. Only one `done` pulse follows each accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when the controller is idle |
| trim_code | output | 5 | Candidate trim code applied to the oscillator |
| meas_req | output | 1 | Measurement request, held until acknowledged |
| meas_ack | input | 1 | One-cycle measurement response strobe |
| meas_count | input | 16 | Reference periods counted in one oscillator period |
| meas_timeout | input | 1 | Measurement timed out; count is ignored |
| done | output | 1 | One-cycle pulse marking a valid `final_code` |
| final_code | output | 5 | Chosen trim code |

## Verification
The handshake properties assume the meter pulses `meas_ack` for a single cycle, and only while `meas_req` is high. The behavioural responder in the bench honours this. It watches `meas_req` on the falling edge, waits a random zero to three cycles, raises the acknowledge for one cycle together with a count from a linear oscillator model, and then waits for the next request. Random models vary the offset and slope of the count curve. Directed models force all timeouts, all counts too high, a constant in-band count and a curve that falls between codes. In the timeout model the ignored count field carries 0xFFFF, which would steer the search the wrong way if it were used.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int TRIM_W = 5;
    localparam int CNT_W  = 16;

    typedef logic [TRIM_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  count_t;

    localparam code_t CODE_MAX = '1;

    typedef struct packed {
        code_t lo;
        code_t hi;
    } bounds_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_APPLY,
        ST_WAIT,
        ST_JUDGE
    } state_t;

    typedef enum logic [1:0] {
        PH_SEARCH,
        PH_END_LO,
        PH_END_HI
    } phase_t;

    function automatic count_t abs_diff(input count_t a, input count_t b);
        return (a > b) ? count_t'(a - b) : count_t'(b - a);
    endfunction

    function automatic logic in_window(input count_t c, input count_t lo, input count_t hi);
        return (c >= lo) && (c <= hi);
    endfunction

endpackage

// File: rtl/trim_bounds.sv
module trim_bounds
    import trim_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    init,
    input  logic    set_lo,
    input  logic    set_hi,
    input  code_t   new_val,
    output bounds_t bnd,
    output code_t   mid,
    output logic    converged
);
    localparam int SUM_W = TRIM_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum       = {1'b0, bnd.lo} + {1'b0, bnd.hi};
        mid       = sum[SUM_W-1:1];
        converged = (mid == bnd.lo);
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            bnd.lo <= '0;
            bnd.hi <= CODE_MAX;
        end else if (set_lo) begin
            bnd.lo <= new_val;
        end else if (set_hi) begin
            bnd.hi <= new_val;
        end
    end
endmodule

// File: rtl/trim_meas_port.sv
module trim_meas_port
    import trim_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch,
    input  logic   meas_ack,
    input  count_t meas_count,
    input  logic   meas_timeout,
    output logic   meas_req,
    output count_t res_count,
    output logic   res_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            meas_req  <= 1'b0;
            res_count <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (launch) begin
                meas_req <= 1'b1;
            end else if (meas_req && meas_ack) begin
                meas_req  <= 1'b0;
                res_count <= meas_timeout ? '0 : meas_count;
                res_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trim_search_ctrl.sv
module trim_search_ctrl
    import trim_pkg::*;
#(
    parameter int TARGET = 794,
    parameter int TOL    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [TRIM_W-1:0] trim_code,
    output logic              meas_req,
    input  logic              meas_ack,
    input  logic [CNT_W-1:0]  meas_count,
    input  logic              meas_timeout,
    output logic              done,
    output logic [TRIM_W-1:0] final_code
);
    localparam count_t BAND_LO = count_t'(TARGET - TOL);
    localparam count_t BAND_HI = count_t'(TARGET + TOL);

    state_t  st;
    phase_t  ph;
    code_t   trim_q;
    code_t   final_q;
    logic    done_q;
    count_t  dist_lo_q;

    bounds_t bnd;
    code_t   mid;
    logic    converged;
    logic    bnd_init;
    logic    bnd_set_lo;
    logic    bnd_set_hi;
    logic    launch;
    count_t  res_count;
    logic    res_valid;
    logic    hit;
    count_t  res_dist;

    always_comb begin
        hit        = in_window(res_count, BAND_LO, BAND_HI);
        res_dist   = abs_diff(res_count, BAND_LO);
        launch     = (st == ST_APPLY);
        bnd_init   = (st == ST_IDLE) && start;
        bnd_set_hi = (st == ST_JUDGE) && (ph == PH_SEARCH) && !hit && (res_count > BAND_HI);
        bnd_set_lo = (st == ST_JUDGE) && (ph == PH_SEARCH) && !hit && (res_count < BAND_LO);
    end

    trim_bounds u_bounds (
        .clk       (clk),
        .rst       (rst),
        .init      (bnd_init),
        .set_lo    (bnd_set_lo),
        .set_hi    (bnd_set_hi),
        .new_val   (trim_q),
        .bnd       (bnd),
        .mid       (mid),
        .converged (converged)
    );

    trim_meas_port u_meas (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .meas_ack     (meas_ack),
        .meas_count   (meas_count),
        .meas_timeout (meas_timeout),
        .meas_req     (meas_req),
        .res_count    (res_count),
        .res_valid    (res_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_SEARCH;
            trim_q    <= '0;
            final_q   <= '0;
            done_q    <= 1'b0;
            dist_lo_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        ph <= PH_SEARCH;
                        st <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (converged) begin
                        ph     <= PH_END_LO;
                        trim_q <= bnd.lo;
                    end else begin
                        trim_q <= mid;
                    end
                    st <= ST_APPLY;
                end
                ST_APPLY: st <= ST_WAIT;
                ST_WAIT: begin
                    if (res_valid) st <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    case (ph)
                        PH_SEARCH: begin
                            if (hit) begin
                                final_q <= trim_q;
                                done_q  <= 1'b1;
                                st      <= ST_IDLE;
                            end else begin
                                st <= ST_PICK;
                            end
                        end
                        PH_END_LO: begin
                            dist_lo_q <= res_dist;
                            trim_q    <= bnd.hi;
                            ph        <= PH_END_HI;
                            st        <= ST_APPLY;
                        end
                        default: begin
                            final_q <= (dist_lo_q < res_dist) ? bnd.lo : bnd.hi;
                            done_q  <= 1'b1;
                            st      <= ST_IDLE;
                        end
                    endcase
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign trim_code  = trim_q;
    assign done       = done_q;
    assign final_code = final_q;
endmodule

// File: rtl/trim_search_chk.sv
module trim_search_chk
    import trim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TRIM_W-1:0] trim_code,
    input logic              meas_req,
    input logic              meas_ack,
    input logic              done,
    input logic [TRIM_W-1:0] final_code
);
    AST_TRIM_SETTLED: assert property (@(posedge clk) disable iff (rst)
        $rose(meas_req) |-> $stable(trim_code)); // R7

    AST_TRIM_HELD: assert property (@(posedge clk) disable iff (rst)
        (meas_req && !meas_ack) |=> $stable(trim_code)); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (meas_req && !meas_ack) |=> meas_req); // R8

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (meas_req && meas_ack) |=> !meas_req); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_FINAL_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(final_code) |-> done); // R9

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !meas_req); // R3
endmodule

bind trim_search_ctrl trim_search_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .trim_code  (trim_code),
    .meas_req   (meas_req),
    .meas_ack   (meas_ack),
    .done       (done),
    .final_code (final_code)
);

// File: tb/test_trim_search_ctrl.sv
module test_trim_search_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  trim_code;
    logic        meas_req;
    logic        meas_ack;
    logic [15:0] meas_count;
    logic        meas_timeout;
    logic        done;
    logic [4:0]  final_code;

    always #10 clk = ~clk;

    trim_search_ctrl i_trim_search_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .trim_code    (trim_code),
        .meas_req     (meas_req),
        .meas_ack     (meas_ack),
        .meas_count   (meas_count),
        .meas_timeout (meas_timeout),
        .done         (done),
        .final_code   (final_code)
    );

    int compared   = 0;
    int mismatched = 0;

    int m_base = 0;
    int m_step = 0;
    bit m_tmo  = 0;

    int   acks      = 0;
    int   viol_trim = 0;
    int   viol_req  = 0;
    int   wait_cnt  = 0;
    bit   ack_given = 0;
    bit   req_prev  = 0;
    logic [4:0] trim_prev = '0;
    logic [4:0] trim_at_req = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_count(input int code);
        int v;
        if (m_tmo) return 0;
        v = m_base + m_step * code;
        if (v > 65535) v = 65535;
        if (v < 0) v = 0;
        return v;
    endfunction

    function automatic int dist792(input int c);
        return (c > 792) ? c - 792 : 792 - c;
    endfunction

    function automatic void expect_run(output int code, output int nmeas);
        int l = 0;
        int r = 31;
        int n = 0;
        int md;
        int c;
        while (1) begin
            md = (l + r) / 2;
            if (md == l) break;
            c = model_count(md);
            n++;
            if (c >= 792 && c <= 796) begin
                code  = md;
                nmeas = n;
                return;
            end
            if (c > 796) r = md;
            else l = md;
        end
        n += 2;
        code  = (dist792(model_count(l)) < dist792(model_count(r))) ? l : r;
        nmeas = n;
    endfunction

    // behavioural meter: acks only while a request is pending, one-cycle strobe
    initial begin
        meas_ack     = 1'b0;
        meas_count   = '0;
        meas_timeout = 1'b0;
        forever begin
            @(negedge clk);
            meas_ack = 1'b0;
            if (ack_given) begin
                if (meas_req) viol_req++;
                ack_given = 0;
            end else if (meas_req) begin
                if (!req_prev) begin
                    trim_at_req = trim_code;
                    if (trim_code !== trim_prev) viol_trim++;
                end
                if (trim_code !== trim_at_req) viol_trim++;
                if (wait_cnt == 0) begin
                    meas_ack = 1'b1;
                    if (m_tmo) begin
                        meas_timeout = 1'b1;
                        meas_count   = 16'hFFFF;
                    end else begin
                        meas_timeout = 1'b0;
                        meas_count   = 16'(model_count(int'(trim_code)));
                    end
                    acks++;
                    ack_given = 1;
                    wait_cnt  = int'($urandom_range(0, 3));
                end else begin
                    wait_cnt--;
                end
            end
            req_prev  = meas_req;
            trim_prev = trim_code;
        end
    end

    task automatic run_case(input string tag, input bit inject_start);
        int exp_code;
        int exp_n;
        int cyc = 0;
        bit got = 0;
        int got_code = 0;
        int stray = 0;
        expect_run(exp_code, exp_n);
        acks      = 0;
        viol_trim = 0;
        viol_req  = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start = (inject_start && (cyc == 4 || cyc == 9)) ? 1'b1 : 1'b0;
            if (done) begin
                got      = 1;
                got_code = int'(final_code);
            end
        end
        start = 1'b0;
        check(got, "R9", "done seen", int'(got), 1);
        check(got_code == exp_code, tag, "final code", got_code, exp_code);
        check(acks == exp_n, "R8", "measurement count", acks, exp_n);
        check(viol_trim == 0, "R7", "trim stability violations", viol_trim, 0);
        check(viol_req == 0, "R8", "request not dropped after ack", viol_req, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done width", int'(done), 0);
        if (inject_start) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (done || meas_req) stray++;
            end
            check(stray == 0, "R10", "activity after ignored start", stray, 0);
            check(int'(final_code) == exp_code, "R9", "final code held", int'(final_code), exp_code);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst   = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(trim_code == 0 && meas_req == 0 && done == 0 && final_code == 0,
              "R1", "outputs in reset", int'({trim_code, meas_req, done, final_code}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(trim_code == 0 && meas_req == 0 && done == 0 && final_code == 0,
              "R1", "outputs after reset", int'({trim_code, meas_req, done, final_code}), 0);

        // R3: constant in-band count, first middle (15) accepted
        m_tmo = 0; m_base = 794; m_step = 0;
        run_case("R3", 0);
        // R5: every measurement times out with garbage count, ends at 31
        m_tmo = 1;
        run_case("R5", 1);
        // R4 / R6 tie: every count too high, ends at 1 by tie rule
        m_tmo = 0; m_base = 2000; m_step = 0;
        run_case("R6", 1);
        // R6: curve between codes, left endpoint 9 strictly closer
        m_base = 700; m_step = 10;
        run_case("R6", 0);
        // R2 / R4: random linear models
        for (int t = 0; t < 40; t++) begin
            m_tmo  = 0;
            m_base = int'($urandom_range(300, 900));
            m_step = int'($urandom_range(1, 40));
            run_case("R4", (t % 5) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule